// File: doc/BRIEF.md
# Maskable and Non-Maskable Interrupt Front End

This block sits between two external interrupt lines and a small processor core. One line is a level-sensitive maskable request. The other is an edge-sensitive non-maskable request. Both lines are synchronised with two flops. The block then tells the core whether an interrupt is pending and of which kind. A non-maskable request outranks a maskable one, and it does not depend on the core's interrupt-enable flag. While the active-low bus-lock input is asserted, every pending indication is hidden.

When the core accepts an interrupt it pulses `take_i`. For a pending non-maskable request this clears the latched flag and produces no strobe. For a maskable request the block drives an active-low acknowledge made of two pulses separated by a gap. It captures the 8-bit vector from the data bus in the last cycle of the second pulse, and it announces the vector with a one-cycle valid strobe.

Top module: `irq_front_end`

## Requirements
- R1: After reset, `pend_o`=0, `pend_nmi_o`=0, `ack_n_o`=1, `vec_o`=0 and `vec_valid_o`=0.
- R2: Take a high `mreq_i` with `int_en_i`=1, `bus_lock_n_i`=1 and no non-maskable request pending. `pend_o` rises two cycles later with `pend_nmi_o`=0. `pend_o` falls two cycles after `mreq_i` falls, and nothing of the request is remembered.
- R3: With `int_en_i`=0 a high `mreq_i` never raises `pend_o`.
- R4: A rising edge on `nmi_i` sets `pend_o` and `pend_nmi_o` three cycles later, whatever `int_en_i` is. Both stay set after `nmi_i` falls, until the request is taken.
- R5: While a non-maskable request is pending, `pend_nmi_o`=1 even if a maskable request is also active. A `take_i` then clears `pend_nmi_o` in the next cycle and leaves `ack_n_o` high.
- R6: Consider a `take_i` while the sequencer is idle, the bus is unlocked, a maskable request is pending and no non-maskable request is pending. `ack_n_o` is then low for PULSE_W cycles starting the next cycle, high for GAP_W cycles, and low again for PULSE_W cycles. Defaults: PULSE_W=2 and GAP_W=1.
- R7: `vec_o` takes the value of `data_i` sampled at the clock edge that ends the second low pulse. From the next cycle `vec_valid_o` is high for exactly one cycle. Data presented during the first pulse is not captured.
- R8: While `bus_lock_n_i`=0, `pend_o` and `pend_nmi_o` are 0 and `take_i` has no effect. A non-maskable edge seen during lock is still latched, and it shows on `pend_nmi_o` in the cycle after the lock is released.
- R9: A `take_i` with nothing pending leaves `ack_n_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mreq_i | input | 1 | Maskable request, level, active high, asynchronous |
| nmi_i | input | 1 | Non-maskable request, rising edge, asynchronous |
| int_en_i | input | 1 | Interrupt-enable flag from the core |
| bus_lock_n_i | input | 1 | Bus locked when low; masks all interrupts |
| take_i | input | 1 | Core accepts the pending interrupt |
| data_i | input | 8 | Low data byte, vector source |
| pend_o | output | 1 | An interrupt is pending |
| pend_nmi_o | output | 1 | The pending interrupt is non-maskable |
| ack_n_o | output | 1 | Active-low acknowledge strobe (maskable only) |
| vec_o | output | 8 | Captured vector |
| vec_valid_o | output | 1 | One-cycle strobe: `vec_o` is new |

## Verification
A level change on `mreq_i` is due on `pend_o` two cycles later, and a rising edge on `nmi_i` is due three cycles later. Effects of `take_i` and `bus_lock_n_i` are due the next cycle. The acknowledge pattern is checked cycle by cycle from the cycle after the take, and the vector and its strobe are checked one cycle after the second pulse ends. The bench drives inputs just after a falling edge and samples at later falling edges. It counts exactly those latencies, first confirming the old value one cycle early where that matters, and it lets random input sets settle for four cycles before comparing them with its own model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_P1, SEQ_GAP, SEQ_P2} seq_t;

  function automatic logic rise_of(input logic now, input logic prev);
    return now & ~prev;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic edge_o,
  output logic pend_o
);
  import irq_pkg::*;
  logic prev_q, pend_q;

  assign edge_o = rise_of(lvl_i, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (edge_o)     pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end
  assign pend_o = pend_q;
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int PULSE_W = 2,
  parameter int GAP_W   = 1,
  parameter int VEC_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VEC_W-1:0] data_i,
  output logic             ack_n_o,
  output logic             idle_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  import irq_pkg::*;
  localparam int CW = cnt_bits(PULSE_W, GAP_W);
  localparam logic [CW-1:0] PW_LAST  = CW'(PULSE_W - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_W - 1);

  seq_t            st_q;
  logic [CW-1:0]   cnt_q;
  logic [VEC_W-1:0] vec_q;
  logic            vv_q;
  logic            cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      vec_q <= '0;
      vv_q  <= 1'b0;
    end else begin
      vv_q <= 1'b0;
      unique case (st_q)
        SEQ_IDLE: if (start_i) begin
          st_q  <= SEQ_P1;
          cnt_q <= PW_LAST;
        end
        SEQ_P1: if (cnt_done) begin
          st_q  <= SEQ_GAP;
          cnt_q <= GAP_LAST;
        end else cnt_q <= cnt_q - 1'b1;
        SEQ_GAP: if (cnt_done) begin
          st_q  <= SEQ_P2;
          cnt_q <= PW_LAST;
        end else cnt_q <= cnt_q - 1'b1;
        SEQ_P2: if (cnt_done) begin
          st_q  <= SEQ_IDLE;
          vec_q <= data_i;
          vv_q  <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign ack_n_o     = !((st_q == SEQ_P1) || (st_q == SEQ_P2));
  assign idle_o      = (st_q == SEQ_IDLE);
  assign vec_o       = vec_q;
  assign vec_valid_o = vv_q;
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end #(
  parameter int PULSE_W = 2,
  parameter int GAP_W   = 1,
  parameter int VEC_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreq_i,
  input  logic             nmi_i,
  input  logic             int_en_i,
  input  logic             bus_lock_n_i,
  input  logic             take_i,
  input  logic [VEC_W-1:0] data_i,
  output logic             pend_o,
  output logic             pend_nmi_o,
  output logic             ack_n_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  logic [1:0] sync_q;
  logic       mreq_s, nmi_s;
  logic       nmi_edge, nmi_pend_q;
  logic       seq_idle, mask_live, mask_accept, nmi_clear, unlocked;

  irq_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({nmi_i, mreq_i}), .q_o(sync_q)
  );
  assign mreq_s = sync_q[0];
  assign nmi_s  = sync_q[1];

  assign unlocked  = bus_lock_n_i;
  assign nmi_clear = take_i & unlocked & nmi_pend_q;

  irq_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .lvl_i(nmi_s), .clr_i(nmi_clear),
    .edge_o(nmi_edge), .pend_o(nmi_pend_q)
  );

  assign mask_live   = mreq_s & int_en_i & seq_idle;
  assign mask_accept = take_i & unlocked & ~nmi_pend_q & mask_live;

  irq_ack_seq #(.PULSE_W(PULSE_W), .GAP_W(GAP_W), .VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .start_i(mask_accept), .data_i(data_i),
    .ack_n_o(ack_n_o), .idle_o(seq_idle), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  assign pend_nmi_o = unlocked & nmi_pend_q;
  assign pend_o     = unlocked & (nmi_pend_q | mask_live);
endmodule

module irq_front_end_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_lock_n_i,
  input logic             take_i,
  input logic [VEC_W-1:0] data_i,
  input logic             pend_o,
  input logic             pend_nmi_o,
  input logic             ack_n_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_valid_o,
  input logic             seq_idle,
  input logic             nmi_pend_q,
  input logic             nmi_edge
);
  // R8
  lock_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_lock_n_i |-> (!pend_o && !pend_nmi_o));
  // R5
  nmi_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_nmi_o |-> pend_o);
  // R5
  nmi_take_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && pend_nmi_o && seq_idle) |=> (ack_n_o && !pend_nmi_o));
  // R6
  mask_take_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && pend_o && !pend_nmi_o && seq_idle) |=> !ack_n_o);
  // R4
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend_q && !(take_i && bus_lock_n_i)) |=> nmi_pend_q);
  // R4
  nmi_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_edge |=> nmi_pend_q);
  // R7
  vec_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o);
  // R7
  vec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (vec_o == $past(data_i)));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && !take_i) |=> ack_n_o);
endmodule

bind irq_front_end irq_front_end_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_lock_n_i(bus_lock_n_i), .take_i(take_i),
  .data_i(data_i), .pend_o(pend_o), .pend_nmi_o(pend_nmi_o), .ack_n_o(ack_n_o),
  .vec_o(vec_o), .vec_valid_o(vec_valid_o), .seq_idle(seq_idle),
  .nmi_pend_q(nmi_pend_q), .nmi_edge(nmi_edge)
);

// File: tb/tb_irq_front_end.sv
`timescale 1ns/1ps
module tb_irq_front_end;
  localparam int PW = 2;
  localparam int GW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mreq = 0, nmi = 0, en = 0, lock_n = 1, take = 0;
  logic [7:0] data = 8'h00;
  logic pend, pend_nmi, ack_n, vv;
  logic [7:0] vec;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_front_end #(.PULSE_W(PW), .GAP_W(GW), .VEC_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .mreq_i(mreq), .nmi_i(nmi), .int_en_i(en),
    .bus_lock_n_i(lock_n), .take_i(take), .data_i(data), .pend_o(pend),
    .pend_nmi_o(pend_nmi), .ack_n_o(ack_n), .vec_o(vec), .vec_valid_o(vv)
  );

  function automatic logic exp_pend(logic m, logic e, logic ln, logic np);
    return ln & (np | (m & e));
  endfunction

  function automatic logic exp_ack_n(int s);
    return !((s <= PW) || ((s > PW + GW) && (s <= 2*PW + GW)));
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_ack(logic [7:0] v);
    take = 1; data = ~v;
    step(1);
    take = 0;
    for (int s = 1; s <= 2*PW + GW + 1; s++) begin
      if (s <= 2*PW + GW) check("R6 ack pattern", ack_n, exp_ack_n(s));
      if (s == PW + GW + 1) data = v;
      if (s < 2*PW + GW + 1) check("R7 no early valid", vv, 0);
      if (s == 2*PW + GW + 1) begin
        check("R7 valid strobe", vv, 1);
        check("R7 vector", vec, v);
        check("R6 ack released", ack_n, 1);
      end
      step(1);
    end
    check("R7 strobe one cycle", vv, 0);
  endtask

  initial begin
    #(20.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    step(3);
    check("R1 pend", pend, 0); check("R1 pend_nmi", pend_nmi, 0);
    check("R1 ack_n", ack_n, 1); check("R1 vec", vec, 0); check("R1 valid", vv, 0);
    rst_n = 1;
    step(2);

    // R9: take with nothing pending
    take = 1; step(1); take = 0;
    check("R9 ack idle", ack_n, 1);

    // R2: maskable level latency
    en = 1; mreq = 1;
    step(1); check("R2 pend not yet", pend, 0);
    step(1); check("R2 pend rises", pend, 1); check("R2 type", pend_nmi, 0);
    mreq = 0;
    step(1); check("R2 still high", pend, 1);
    step(1); check("R2 pend falls", pend, 0);
    step(3); check("R2 not remembered", pend, 0);

    // R3: enable low
    en = 0; mreq = 1; step(4);
    check("R3 masked", pend, 0);
    mreq = 0; step(3);

    // R4: NMI edge ignores enable and is latched
    nmi = 1;
    step(2); check("R4 not yet", pend_nmi, 0);
    step(1); check("R4 nmi pend", pend_nmi, 1); check("R4 pend", pend, 1);
    nmi = 0; step(4);
    check("R4 held after fall", pend_nmi, 1);

    // R5: priority over maskable, take clears without ack
    en = 1; mreq = 1; step(3);
    check("R5 nmi priority", pend_nmi, 1);
    take = 1; step(1); take = 0;
    check("R5 nmi cleared", pend_nmi, 0);
    check("R5 no ack", ack_n, 1);
    check("R5 maskable shows", pend, 1);
    step(1); check("R5 no ack later", ack_n, 1);

    // R6 R7: maskable acknowledge with vector
    run_ack(8'hA5);
    run_ack(8'h3C);

    // R8: lock masks, take ignored, NMI still latched
    lock_n = 0; step(1);
    check("R8 pend masked", pend, 0);
    nmi = 1; step(2); nmi = 0; step(3);
    check("R8 nmi hidden", pend_nmi, 0);
    take = 1; step(1); take = 0;
    check("R8 take ignored", ack_n, 1);
    step(1); check("R8 still no ack", ack_n, 1);
    lock_n = 1; step(1);
    check("R8 nmi after unlock", pend_nmi, 1);
    take = 1; step(1); take = 0;
    check("R8 nmi taken", pend_nmi, 0);
    mreq = 0; step(3);

    // random level patterns against the model
    for (int i = 0; i < 40; i++) begin
      mreq = $urandom % 2; en = $urandom % 2; lock_n = $urandom % 2;
      step(4);
      check("R2 R3 R8 random pend", pend, exp_pend(mreq, en, lock_n, 1'b0));
      check("R8 random type", pend_nmi, 0);
    end

    // random acknowledge vectors
    mreq = 1; en = 1; lock_n = 1; step(3);
    for (int i = 0; i < 12; i++) begin
      run_ack(8'($urandom));
      step($urandom % 3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule